// File: doc/BRIEF.md
# Time-of-Day Update Sequencer

This block runs the once-per-second update of a seconds/minutes/hours register set that software reads and writes. It holds two copies of the three time bytes and of the three alarm bytes. The internal copy is the one that counts. The user copy is the one software sees. Each 1 Hz tick starts an update. A status flag goes high first and stays high for a fixed number of pulses of a fast timebase. On the last of those pulses the internal time advances, the user copy takes the new values, the alarm bytes are compared, and the update-ended flag is raised.

A freeze input stops only the transfer into the user copy. The internal counters and the alarm comparison keep running. While the block is frozen, software may rewrite the user copy. When freeze is released, the user copy is loaded into the internal counters. Reading the flag register clears the update-ended and alarm flags. An interrupt request is the OR of every flag that is both set and enabled.

Top module: `rtc_update_ctrl`

## Requirements
- R1: Each tick_1hz_i pulse received while no update is pending starts one update, whatever freeze_i is, and every update sets uf_o.
- R2: While freeze_i is 1, the user copy changes only by writes. The internal time still advances, and the alarm is compared against the internal time.
- R3: uip_o rises on the clock edge that samples tick_1hz_i. The update happens on the edge that samples the LEAD_TICKS-th lead_tick_i pulse after that. On that edge uip_o falls and the user copy changes. Until then the user copy stays put.
- R4: While uip_o is low, lead_tick_i pulses have no effect, and the user copy changes only through writes.
- R5: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0. All values are binary.
- R6: af_o is set at an update when each of the three alarm bytes either equals the new internal time byte or has bits [7:6] = 2'b11, which is the don't-care code.
- R7: A flag_rd_i pulse clears uf_o and af_o. If an update happens in the same cycle, the update's setting wins.
- R8: irq_o = (uf_o & uf_en_i) | (af_o & af_en_i).
- R9: While freeze_i is 1, a write changes only the user copy. When freeze_i goes from 1 to 0, the user copy is loaded into the internal copy.
- R10: wr_sel_i selects the byte to write: 0 seconds, 1 minutes, 2 hours, 3 alarm seconds, 4 alarm minutes, 5 alarm hours. Values 6 and 7 write nothing. With freeze_i at 0, a write updates both copies.
- R11: After reset, all bytes, uip_o, uf_o, af_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1hz_i | input | 1 | One-cycle pulse once per second |
| lead_tick_i | input | 1 | One-cycle pulse of the fast timebase that times the lead interval |
| freeze_i | input | 1 | Holds the user copy when 1 |
| wr_en_i | input | 1 | User write strobe |
| wr_sel_i | input | 3 | Byte select for the write |
| wr_data_i | input | 8 | Write data |
| flag_rd_i | input | 1 | Flag register read strobe, clears the flags |
| uf_en_i | input | 1 | Update-ended interrupt enable |
| af_en_i | input | 1 | Alarm interrupt enable |
| usr_sec_o | output | 8 | User copy: seconds |
| usr_min_o | output | 8 | User copy: minutes |
| usr_hr_o | output | 8 | User copy: hours |
| usr_alm_sec_o | output | 8 | User copy: alarm seconds |
| usr_alm_min_o | output | 8 | User copy: alarm minutes |
| usr_alm_hr_o | output | 8 | User copy: alarm hours |
| uip_o | output | 1 | Update in progress |
| uf_o | output | 1 | Update-ended flag |
| af_o | output | 1 | Alarm flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with LEAD_TICKS set to 4 and keeps the default wrap limits. With the shorter lead, the whole lead window can be walked pulse by pulse. The bench checks the user copy just before the last lead pulse and just after it, and it can land a flag read on exactly the update edge. The default limits of 59, 59 and 23 put the full carry from 23:59:59 and the don't-care alarm cases within a single update each.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_TIME   = 3;
  localparam int NUM_FIELDS = 2 * NUM_TIME;
  localparam int SEL_W      = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [SEL_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HR   = 3'd2,
    F_ASEC = 3'd3,
    F_AMIN = 3'd4,
    F_AHR  = 3'd5
  } field_e;

  localparam logic [1:0] WILD_TAG = 2'b11;
endpackage

// File: rtl/rtc_lead_timer.sv
module rtc_lead_timer #(
  parameter int LEAD_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lead_i,
  output logic busy_o,
  output logic upd_o
);
  localparam int CNT_W = (LEAD_TICKS > 1) ? $clog2(LEAD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LEAD_TICKS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = busy_q;
  assign upd_o  = busy_q && lead_i && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (tick_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (lead_i) begin
      if (upd_o) busy_q <= 1'b0;
      else       cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_tod_step.sv
module rtc_tod_step
  import rtc_upd_pkg::*;
#(
  parameter logic [NUM_TIME-1:0][BYTE_W-1:0] LAST = {8'd23, 8'd59, 8'd59}
) (
  input  logic [NUM_TIME-1:0][BYTE_W-1:0] cur_i,
  output logic [NUM_TIME-1:0][BYTE_W-1:0] nxt_o
);
  logic [NUM_TIME-1:0] carry;
  logic [NUM_TIME-1:0] wrap;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_digit
    // out-of-range values also wrap
    assign wrap[i]  = (cur_i[i] >= LAST[i]);
    assign nxt_o[i] = !carry[i] ? cur_i[i] : (wrap[i] ? '0 : cur_i[i] + 1'b1);
    if (i < NUM_TIME - 1) begin : g_carry
      assign carry[i+1] = carry[i] & wrap[i];
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_upd_pkg::*;
(
  input  logic [NUM_TIME-1:0][BYTE_W-1:0] tm_i,
  input  logic [NUM_TIME-1:0][BYTE_W-1:0] alm_i,
  output logic                            match_o
);
  logic [NUM_TIME-1:0] hit;

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_pos
    assign hit[i] = (alm_i[i][BYTE_W-1 -: 2] == WILD_TAG) || (alm_i[i] == tm_i[i]);
  end

  assign match_o = &hit;
endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
  import rtc_upd_pkg::*;
#(
  parameter int LEAD_TICKS = 8,
  parameter int SEC_LAST   = 59,
  parameter int MIN_LAST   = 59,
  parameter int HR_LAST    = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_1hz_i,
  input  logic             lead_tick_i,
  input  logic             freeze_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic             flag_rd_i,
  input  logic             uf_en_i,
  input  logic             af_en_i,
  output logic [BYTE_W-1:0] usr_sec_o,
  output logic [BYTE_W-1:0] usr_min_o,
  output logic [BYTE_W-1:0] usr_hr_o,
  output logic [BYTE_W-1:0] usr_alm_sec_o,
  output logic [BYTE_W-1:0] usr_alm_min_o,
  output logic [BYTE_W-1:0] usr_alm_hr_o,
  output logic             uip_o,
  output logic             uf_o,
  output logic             af_o,
  output logic             irq_o
);
  localparam logic [NUM_TIME-1:0][BYTE_W-1:0] LIMITS =
    {BYTE_W'(HR_LAST), BYTE_W'(MIN_LAST), BYTE_W'(SEC_LAST)};

  logic [NUM_FIELDS-1:0][BYTE_W-1:0] int_q, int_d, usr_q, usr_d;
  logic [NUM_TIME-1:0][BYTE_W-1:0]   step_nxt;
  logic upd, busy, match, frz_q, release_w, uf_q, af_q;

  rtc_lead_timer #(.LEAD_TICKS(LEAD_TICKS)) u_lead (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_1hz_i),
    .lead_i(lead_tick_i),
    .busy_o(busy),
    .upd_o (upd)
  );

  rtc_tod_step #(.LAST(LIMITS)) u_step (
    .cur_i(int_q[NUM_TIME-1:0]),
    .nxt_o(step_nxt)
  );

  rtc_alarm_cmp u_alarm (
    .tm_i   (step_nxt),
    .alm_i  (int_q[NUM_FIELDS-1:NUM_TIME]),
    .match_o(match)
  );

  assign release_w = frz_q && !freeze_i;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    logic        wr_hit;
    logic [BYTE_W-1:0] adv;
    assign wr_hit = wr_en_i && (wr_sel_i == SEL_W'(f));
    if (f < NUM_TIME) begin : g_time
      assign adv = step_nxt[f];
    end else begin : g_alm
      assign adv = int_q[f];
    end
    // internal copy: direct write, reload on release, then count
    assign int_d[f] = (wr_hit && !freeze_i) ? wr_data_i :
                      release_w             ? usr_q[f]  :
                      upd                   ? adv       : int_q[f];
    // user copy: writes always land, transfer only when not held
    assign usr_d[f] = wr_hit                             ? wr_data_i :
                      (upd && !freeze_i && !release_w)   ? adv       : usr_q[f];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= '0;
      usr_q <= '0;
      frz_q <= 1'b0;
      uf_q  <= 1'b0;
      af_q  <= 1'b0;
    end else begin
      int_q <= int_d;
      usr_q <= usr_d;
      frz_q <= freeze_i;
      if (upd)            uf_q <= 1'b1;
      else if (flag_rd_i) uf_q <= 1'b0;
      if (upd && match)   af_q <= 1'b1;
      else if (flag_rd_i) af_q <= 1'b0;
    end
  end

  assign usr_sec_o     = usr_q[F_SEC];
  assign usr_min_o     = usr_q[F_MIN];
  assign usr_hr_o      = usr_q[F_HR];
  assign usr_alm_sec_o = usr_q[F_ASEC];
  assign usr_alm_min_o = usr_q[F_AMIN];
  assign usr_alm_hr_o  = usr_q[F_AHR];
  assign uip_o         = busy;
  assign uf_o          = uf_q;
  assign af_o          = af_q;
  assign irq_o         = (uf_q && uf_en_i) || (af_q && af_en_i);
endmodule

// File: rtl/rtc_update_ctrl_chk.sv
module rtc_update_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       freeze_i,
  input logic       wr_en_i,
  input logic       flag_rd_i,
  input logic       uip_o,
  input logic       uf_o,
  input logic       af_o,
  input logic [7:0] usr_sec_o
);
  AST_UPDATE_SETS_UF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(uip_o) |-> uf_o); // R1

  AST_FREEZE_HOLDS_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(freeze_i) && !$past(wr_en_i)) |-> $stable(usr_sec_o)); // R2

  AST_IDLE_USER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(uip_o) && !$past(wr_en_i)) |-> $stable(usr_sec_o)); // R4

  AST_ALARM_AT_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af_o) |-> uf_o); // R6

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_rd_i) && !$fell(uip_o)) |-> (!uf_o && !af_o)); // R7
endmodule

bind rtc_update_ctrl rtc_update_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .freeze_i (freeze_i),
  .wr_en_i  (wr_en_i),
  .flag_rd_i(flag_rd_i),
  .uip_o    (uip_o),
  .uf_o     (uf_o),
  .af_o     (af_o),
  .usr_sec_o(usr_sec_o)
);

// File: tb/tb_rtc_update_ctrl.sv
module tb_rtc_update_ctrl;
  localparam int TB_LEAD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, lead = 1'b0, frz = 1'b0, wr_en = 1'b0, frd = 1'b0;
  logic uf_en = 1'b0, af_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec, mins, hr, asec, amin, ahr;
  logic uip, uf, af, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_update_ctrl #(.LEAD_TICKS(TB_LEAD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_1hz_i(tick), .lead_tick_i(lead),
    .freeze_i(frz), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .flag_rd_i(frd), .uf_en_i(uf_en), .af_en_i(af_en),
    .usr_sec_o(sec), .usr_min_o(mins), .usr_hr_o(hr),
    .usr_alm_sec_o(asec), .usr_alm_min_o(amin), .usr_alm_hr_o(ahr),
    .uip_o(uip), .uf_o(uf), .af_o(af), .irq_o(irq)
  );

  // sec, min, hr, alarm sec, alarm min, alarm hr, exp sec, exp min, exp hr, exp af
  localparam logic [7:0] VEC [9][10] = '{
    '{8'd10, 8'd5,  8'd3,  8'd0,   8'd0,   8'd0,   8'd11, 8'd5,  8'd3,  8'd0},
    '{8'd59, 8'd5,  8'd3,  8'd0,   8'd0,   8'd0,   8'd0,  8'd6,  8'd3,  8'd0},
    '{8'd59, 8'd59, 8'd3,  8'd0,   8'd0,   8'd0,   8'd0,  8'd0,  8'd4,  8'd0},
    '{8'd59, 8'd59, 8'd23, 8'd0,   8'd0,   8'd0,   8'd0,  8'd0,  8'd0,  8'd1},
    '{8'd20, 8'd30, 8'd12, 8'd21,  8'd30,  8'd12,  8'd21, 8'd30, 8'd12, 8'd1},
    '{8'd20, 8'd30, 8'd12, 8'hC0,  8'hC0,  8'hC0,  8'd21, 8'd30, 8'd12, 8'd1},
    '{8'd20, 8'd30, 8'd12, 8'd21,  8'd31,  8'd12,  8'd21, 8'd30, 8'd12, 8'd0},
    '{8'd40, 8'd10, 8'd7,  8'd41,  8'd10,  8'hFF,  8'd41, 8'd10, 8'd7,  8'd1},
    '{8'd5,  8'd0,  8'd0,  8'hC0,  8'd1,   8'hC0,  8'd6,  8'd0,  8'd0,  8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse_lead();
    @(negedge clk) lead = 1'b1;
    @(negedge clk) lead = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk) frd = 1'b1;
    @(negedge clk) frd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_sel = s; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic do_update();
    pulse_tick();
    repeat (TB_LEAD) pulse_lead();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 time", {sec, mins, hr}, 24'h0);
    chk("R11 alarm", {asec, amin, ahr}, 24'h0);
    chk("R11 flags", {uip, uf, af, irq}, 4'h0);

    // table walk: R5 wrap, R6 alarm match and don't-care, R10 writes at freeze 0
    for (int v = 0; v < 9; v++) begin
      for (int f = 0; f < 6; f++) wr(3'(f), VEC[v][f]);
      pulse_rd();
      do_update();
      chk("R5 time", {sec, mins, hr}, {VEC[v][6], VEC[v][7], VEC[v][8]});
      chk("R6 alarm flag", af, VEC[v][9][0]);
      chk("R10 alarm bytes", {asec, amin, ahr}, {VEC[v][3], VEC[v][4], VEC[v][5]});
      chk("R1 uf set", uf, 1'b1);
    end

    // R3 lead window
    wr(3'd0, 8'd30); wr(3'd1, 8'd0); wr(3'd2, 8'd1);
    wr(3'd3, 8'd0); wr(3'd4, 8'd0); wr(3'd5, 8'd0);
    pulse_rd();
    pulse_tick();
    chk("R3 uip rises", uip, 1'b1);
    repeat (TB_LEAD - 1) pulse_lead();
    chk("R3 uip held", uip, 1'b1);
    chk("R3 user held in lead", sec, 8'd30);
    pulse_lead();
    chk("R3 uip falls", uip, 1'b0);
    chk("R3 transfer", sec, 8'd31);

    // R4 lead pulses while idle do nothing
    repeat (TB_LEAD + 1) pulse_lead();
    chk("R4 idle uip", uip, 1'b0);
    chk("R4 idle user", sec, 8'd31);

    // R10 select 6 and 7 ignored
    wr(3'd6, 8'd9); wr(3'd7, 8'd9);
    chk("R10 bad sel", {sec, mins, hr, asec, amin, ahr}, {8'd31, 8'd0, 8'd1, 24'h0});

    // R7 read clears, update in same cycle wins
    pulse_rd();
    chk("R7 cleared", {uf, af}, 2'b00);
    pulse_tick();
    repeat (TB_LEAD - 1) pulse_lead();
    @(negedge clk) begin lead = 1'b1; frd = 1'b1; end
    @(negedge clk) begin lead = 1'b0; frd = 1'b0; end
    chk("R7 set wins", uf, 1'b1);

    // R8 irq gating
    uf_en = 1'b0; af_en = 1'b0;
    @(negedge clk);
    chk("R8 masked", irq, 1'b0);
    uf_en = 1'b1;
    @(negedge clk);
    chk("R8 uf enabled", irq, 1'b1);

    // R2 freeze: user held, internal advances and hits alarm
    wr(3'd0, 8'd10); wr(3'd1, 8'd0); wr(3'd2, 8'd0);
    wr(3'd3, 8'd12); wr(3'd4, 8'd0); wr(3'd5, 8'd0);
    pulse_rd();
    uf_en = 1'b0; af_en = 1'b1;
    @(negedge clk) frz = 1'b1;
    do_update();
    chk("R2 user frozen", sec, 8'd10);
    chk("R1 uf under freeze", uf, 1'b1);
    chk("R2 no alarm yet", af, 1'b0);
    pulse_rd();
    do_update();
    chk("R2 user still frozen", sec, 8'd10);
    chk("R2 internal reached alarm", af, 1'b1);
    chk("R8 af enabled", irq, 1'b1);
    af_en = 1'b0;
    @(negedge clk);
    chk("R8 af masked", irq, 1'b0);

    // R9 frozen write touches user only, release reloads internal
    pulse_rd();
    wr(3'd0, 8'd40);
    chk("R9 user written", sec, 8'd40);
    do_update();
    chk("R9 still 40", sec, 8'd40);
    chk("R9 internal past alarm", af, 1'b0);
    @(negedge clk) frz = 1'b0;
    @(negedge clk);
    chk("R9 release keeps user", sec, 8'd40);
    do_update();
    chk("R9 reloaded count", sec, 8'd41);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule